// File: doc/BRIEF.md
# Elastic Three-Stage Processing Pipeline

This block carries data words from a producer to a consumer through three registered processing stages. Each stage applies a small fixed transform: it adds a stage-specific constant. A valid/ready handshake sits on both sides. The producer may leave cycles empty, and the consumer may refuse data on any cycle.

Every stage keeps its own occupancy bit. A stage takes new content when it is empty, or when its current content moves on in the same cycle. Empty stages therefore fill from behind even while the consumer is stalled. Gaps between items close up.

The input ready signal is derived from those occupancy bits. The producer is held off only when every stage is full and the consumer is not taking data. When both sides are always active, the block moves one item per cycle.

Top module: `epipe3`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `out_valid` is 0 and `in_ready` is 1. A reset asserted in mid-run discards every item held inside the block.
- R2: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` at 1, with `out_data` unchanged.
- R3: `in_ready` is 0 only when all DEPTH stages hold an item and `out_ready` is 0. In every other cycle it is 1.
- R4: An item accepted into an empty block, with `out_ready` held at 1, is first offered on the output after exactly three rising edges. The edge that accepts it counts as the first.
- R5: With `in_valid` and `out_ready` held at 1, one item leaves on every cycle once the pipeline has filled, and `in_ready` never drops.
- R6: Items leave in the order they were accepted. No item is lost or duplicated under any pattern of producer gaps and consumer stalls.
- R7: While the consumer is stalled, empty stages are filled from behind. Items offered with idle cycles between them are still all accepted until DEPTH items are held.
- R8: Stage i (counting from 0 at the input) adds BASE_ADD+i, modulo 2^DATA_W. With the defaults (DATA_W=8, DEPTH=3, BASE_ADD=1), `out_data` equals the accepted `in_data` plus 6, modulo 256.
- R9: With `out_ready` held at 0 and `in_valid` held at 1, an empty block accepts exactly DEPTH items and then holds `in_ready` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Producer offers `in_data` this cycle |
| in_data | input | DATA_W | Producer data word |
| in_ready | output | 1 | Block can absorb an item this cycle |
| out_valid | output | 1 | Block offers `out_data` this cycle |
| out_data | output | DATA_W | Processed data word |
| out_ready | input | 1 | Consumer takes `out_data` this cycle |

## Verification
The bench builds the block with its defaults: 8-bit data, three stages and a base increment of 1. Under these settings every output is the input plus 6, modulo 256, and the whole 256-value input space fits in one streaming pass. Three stages also keep the state space small. All 16×16 pairings of 4-cycle producer and consumer duty patterns can be swept, which reaches every mix of occupancy, bubble and stall, together with the full and empty boundaries of the ready logic.

// File: rtl/epipe_pkg.sv
package epipe_pkg;

  // Increment applied by stage idx (0 at the input side).
  function automatic int unsigned stage_add(input int unsigned base, input int unsigned idx);
    return base + idx;
  endfunction

  // Total increment over a chain of n stages.
  function automatic int unsigned chain_add(input int unsigned base, input int unsigned n);
    return n * base + (n * (n - 1)) / 2;
  endfunction

endpackage

// File: rtl/epipe_xform.sv
module epipe_xform #(
  parameter int unsigned W   = 8,
  parameter int unsigned ADD = 1
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);

  localparam logic [W-1:0] K = W'(ADD);

  always_comb begin
    y = a + K;
  end

endmodule

// File: rtl/epipe_stage.sv
module epipe_stage #(
  parameter int unsigned W   = 8,
  parameter int unsigned ADD = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  input  logic [W-1:0] up_data,
  output logic         up_ready,
  input  logic         dn_ready,
  output logic         dn_valid,
  output logic [W-1:0] dn_data
);

  logic         full_q;
  logic         full_d;
  logic         load;
  logic [W-1:0] dat_q;
  logic [W-1:0] xf;

  epipe_xform #(.W(W), .ADD(ADD)) i_xform (
    .a (up_data),
    .y (xf)
  );

  // Room exists if empty, or if the held item leaves this cycle.
  assign up_ready = !full_q || dn_ready;
  assign load     = up_valid && up_ready;

  always_comb begin
    full_d = full_q;
    if (load) begin
      full_d = 1'b1;
    end else if (dn_ready) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  // Datapath register: clock-enabled, no reset.
  always_ff @(posedge clk) begin
    if (load) begin
      dat_q <= xf;
    end
  end

  assign dn_valid = full_q;
  assign dn_data  = dat_q;

  // A held item that is not taken stays put, unchanged.
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !dn_ready) |=> (full_q && $stable(dat_q)));

  // An item leaving with nothing behind it empties the stage.
  p_stage_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && dn_ready && !up_valid) |=> !full_q);

endmodule

// File: rtl/epipe3.sv
module epipe3 #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEPTH    = 3,
  parameter int unsigned BASE_ADD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);

  localparam int unsigned LINKS = DEPTH + 1;

  // Link k is the boundary in front of stage k; link DEPTH is the output.
  logic [LINKS-1:0]  lv;
  logic [LINKS-1:0]  lr;
  logic [DATA_W-1:0] ld [LINKS];

  assign lv[0]     = in_valid;
  assign ld[0]     = in_data;
  assign lr[DEPTH] = out_ready;
  assign in_ready  = lr[0];
  assign out_valid = lv[DEPTH];
  assign out_data  = ld[DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    epipe_stage #(
      .W   (DATA_W),
      .ADD (epipe_pkg::stage_add(BASE_ADD, i))
    ) i_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (lv[i]),
      .up_data  (ld[i]),
      .up_ready (lr[i]),
      .dn_ready (lr[i+1]),
      .dn_valid (lv[i+1]),
      .dn_data  (ld[i+1])
    );
  end

  // Back-pressure reaches the producer only when every slot is taken.
  p_ready_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (&lv[DEPTH:1] && !out_ready));

  // An open consumer never stalls the producer.
  p_sink_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  // An offered output persists with stable data until taken.
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // A full stage with an empty successor moves forward on the next edge.
  for (genvar j = 1; j < DEPTH; j++) begin : g_bubble
    p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lv[j] && !lv[j+1]) |=> lv[j+1]);
  end

endmodule

// File: tb/test_epipe3.sv
`timescale 1ns/1ps
module test_epipe3;

  localparam int W   = 8;
  localparam int DEP = 3;
  localparam int INC = 6;   // 1 + 2 + 3

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic         in_ready;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_ready;

  int n_run, n_fail;
  int cyc, n_in, n_out, last_in_cyc, last_out_cyc;
  logic [W-1:0] next_val;
  logic clr_in, prev_stall;
  logic [W-1:0] prev_data;
  logic [W-1:0] exp_q[$];

  epipe3 #(.DATA_W(W), .DEPTH(DEP), .BASE_ADD(1)) i_epipe3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // One cycle: drive at the falling edge, sample 3 ns later, before the rising edge.
  task automatic tick(input bit src, input bit snk);
    logic [W-1:0] e;
    @(negedge clk);
    if (clr_in) begin in_valid = 1'b0; clr_in = 1'b0; end
    if (!in_valid && src) begin
      in_valid = 1'b1; in_data = next_val; next_val = next_val + 1'b1;
    end
    out_ready = snk;
    #3;
    // R3: ready depends only on occupancy and the sink.
    chk(in_ready == ((exp_q.size() < DEP) || out_ready), "R3 in_ready", int'(in_ready),
        int'((exp_q.size() < DEP) || out_ready));
    if (prev_stall) begin
      chk(out_valid && out_data == prev_data, "R2 hold", int'(out_data), int'(prev_data));
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 extra output", int'(out_data), -1);
      end else begin
        e = exp_q.pop_front();
        chk(out_data == e, "R6/R8 data", int'(out_data), int'(e));
      end
      n_out++; last_out_cyc = cyc;
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(in_data + W'(INC));
      n_in++; last_in_cyc = cyc; clr_in = 1'b1;
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    cyc++;
  endtask

  task automatic drain();
    for (int k = 0; k < 10; k++) tick(1'b0, 1'b1);
    chk(exp_q.size() == 0, "R6 lost items", exp_q.size(), 0);
  endtask

  initial begin
    n_run = 0; n_fail = 0; cyc = 0; n_in = 0; n_out = 0;
    last_in_cyc = 0; last_out_cyc = 0; next_val = '0;
    clr_in = 1'b0; prev_stall = 1'b0; prev_data = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk(!out_valid && in_ready, "R1 in reset", {30'd0, out_valid, in_ready}, 1);
    @(negedge clk); rst_n = 1'b1; #3;
    chk(!out_valid && in_ready, "R1 after release", {30'd0, out_valid, in_ready}, 1);

    // R4: latency from an empty block.
    tick(1'b1, 1'b1);
    for (int k = 0; k < 5; k++) tick(1'b0, 1'b1);
    chk(last_out_cyc - last_in_cyc == 3, "R4 latency", last_out_cyc - last_in_cyc, 3);
    drain();

    // R8: every input value streamed at full rate.
    for (int k = 0; k < 256; k++) tick(1'b1, 1'b1);
    drain();

    // R5: throughput with both sides always active.
    n_out = 0;
    for (int k = 0; k < 60; k++) tick(1'b1, 1'b1);
    chk(n_out == 57, "R5 throughput", n_out, 57);
    drain();

    // R9: stalled sink, constant source.
    n_in = 0;
    for (int k = 0; k < 8; k++) tick(1'b1, 1'b0);
    chk(n_in == DEP, "R9 accepted under stall", n_in, DEP);
    chk(!in_ready, "R9 backpressure", int'(in_ready), 0);
    drain();

    // R7: gapped source, stalled sink.
    n_in = 0;
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    chk(n_in == DEP, "R7 gaps collapsed", n_in, DEP);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    chk(n_in == DEP && !in_ready, "R7 full after gaps", n_in, DEP);
    drain();

    // R6/R2: all pairings of 4-cycle source and sink duty patterns.
    for (int sp = 0; sp < 16; sp++) begin
      for (int kp = 0; kp < 16; kp++) begin
        for (int c = 0; c < 24; c++) begin
          tick(sp[c % 4] | (sp == 0 && c == 0), kp[c % 4] | (kp == 0 && c > 20));
        end
        drain();
      end
    end

    // R1: reset in mid-run discards the contents.
    for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0; clr_in = 1'b0; #3;
    chk(!out_valid && in_ready, "R1 mid-run reset", {30'd0, out_valid, in_ready}, 1);
    exp_q.delete(); prev_stall = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) tick(1'b0, 1'b1);
    chk(n_out >= 0 && !out_valid, "R1 empty after reset", int'(out_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule